// File: doc/BRIEF.md
# Quantized Playfield Serializer

This block draws a coarse background layer across a video line. A set of playfield bit registers, written by a processor at any moment, holds one bit per 4-pixel block. The serializer walks a horizontal pixel counter and outputs the bit of the block under the beam. It also outputs a pixel colour chosen from a foreground and a background colour register.

Writes are never shown mid-block. The bit for each block is fetched into a holding latch on one horizontal phase and moved to the output on a second, non-overlapping phase. Both phases repeat every 4 pixels. As a result, the output changes only on 4-pixel boundaries. The visible delay of a playfield write depends on where in the line it lands relative to the fetch of the affected block. Colour writes bypass this gating and show on the very next pixel.

Top module: `pf_quant_serializer`

## Requirements
- R1: While reset is held, `hpos` is 0, `pf_pix` is 0 and `pix_col` is 0; all playfield bits and both colours clear to 0.
- R2: `hpos` advances by one each clock, from 0 up to 159, then returns to 0.
- R3: During pixel p, `pf_pix` equals playfield block floor(p/4). Bit j of the byte written at address r (r = 0..4) is block 8r+j.
- R4: `pf_pix` changes value only on pixels whose position is a multiple of 4.
- R5: Let a write carrying block k (k >= 1) happen in the cycle where `hpos` = w. It is shown from pixel 4k of the same line if w <= 4k-4, otherwise from pixel 4k of the next line. Block 0 is fetched at pixel 157, so it counts as block 40 of the preceding line.
- R6: Address 5 holds the foreground colour and address 6 the background colour; each uses `wr_data[6:0]`. A colour write in the cycle with `hpos` = w changes `pix_col` from pixel w+1, while pixel w still shows the old colour. `pix_col` is the foreground colour when `pf_pix` is 1, otherwise the background colour.
- R7: A write to address 7 changes nothing: neither the next pixel nor any later line.
- R8: With no writes, every line produces the same pixel stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0-4 playfield bytes, 5 foreground, 6 background |
| wr_data | input | 8 | Write data |
| hpos | output | 8 | Current pixel position on the line |
| pf_pix | output | 1 | Playfield bit for the current pixel |
| pix_col | output | 7 | Colour of the current pixel |

## Verification
The properties assume at most one register write per cycle. They also assume no write is issued in the two cycles after `rst_n` rises, while the internal reset is still held. A write strobed then would be dropped, and the colour properties would fire. The bench drives writes only on falling edges, one cycle per strobe, and waits well past reset release before its first write. The ignored-address property is only claimed away from the last pixel of a block, and the stimulus places its ignored write mid-block to match.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Pixels covered by one playfield bit; the phase decode relies on 4.
  localparam int PFQ_BLK_PIX = 4;

  // Two non-overlapping horizontal strobes inside every block.
  typedef struct packed {
    logic fetch;  // load the next block's bit into the holding latch
    logic drive;  // move the holding latch onto the output
  } pfq_phase_t;

endpackage

// File: rtl/pfq_hcount.sv
module pfq_hcount
  import pfq_pkg::*;
#(
  parameter int LINE_PIX = 160,
  parameter int HW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos,
  output pfq_phase_t    phase
);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == HW'(LINE_PIX - 1));
    cnt_d  = at_end ? '0 : cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fetch on the second pixel of a block, drive on the last one.
  always_comb begin
    phase.fetch = (cnt_q[1:0] == 2'd1);
    phase.drive = (cnt_q[1:0] == 2'd3);
  end

  assign hpos = cnt_q;

endmodule

// File: rtl/pfq_regs.sv
module pfq_regs #(
  parameter int NBLK  = 40,
  parameter int REG_W = 8,
  parameter int COLW  = 7,
  parameter int NREG  = 5,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [NBLK-1:0]  pf_bits,
  output logic [COLW-1:0]  fg_col,
  output logic [COLW-1:0]  bg_col
);

  logic [NBLK-1:0] pf_q, pf_d;
  logic [COLW-1:0] fg_q, fg_d, bg_q, bg_d;
  logic            fg_we, bg_we;

  for (genvar r = 0; r < NREG; r++) begin : g_byte
    logic byte_we;
    assign byte_we = wr_en && (wr_addr == AW'(r));
    assign pf_d[r*REG_W +: REG_W] = byte_we ? wr_data : pf_q[r*REG_W +: REG_W];
  end

  if (NBLK > NREG*REG_W) begin : g_tail
    assign pf_d[NBLK-1:NREG*REG_W] = pf_q[NBLK-1:NREG*REG_W];
  end

  always_comb begin
    fg_we = wr_en && (wr_addr == AW'(NREG));
    bg_we = wr_en && (wr_addr == AW'(NREG + 1));
    fg_d  = fg_we ? wr_data[COLW-1:0] : fg_q;
    bg_d  = bg_we ? wr_data[COLW-1:0] : bg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= '0;
      fg_q <= '0;
      bg_q <= '0;
    end else begin
      pf_q <= pf_d;
      fg_q <= fg_d;
      bg_q <= bg_d;
    end
  end

  assign pf_bits = pf_q;
  assign fg_col  = fg_q;
  assign bg_col  = bg_q;

endmodule

// File: rtl/pfq_shifter.sv
module pfq_shifter
  import pfq_pkg::*;
#(
  parameter int NBLK = 40,
  parameter int HW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBLK-1:0] pf_bits,
  input  logic [HW-1:0]   hpos,
  input  pfq_phase_t      phase,
  output logic            pix_bit
);

  localparam int BW = $clog2(NBLK);

  logic [BW-1:0] blk, nxt_blk;
  logic          hold_q, hold_d;
  logic          out_q, out_d;

  always_comb begin
    blk     = BW'(hpos >> 2);
    nxt_blk = (blk == BW'(NBLK - 1)) ? '0 : blk + BW'(1);
    hold_d  = phase.fetch ? pf_bits[nxt_blk] : hold_q;
    out_d   = phase.drive ? hold_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign pix_bit = out_q;

endmodule

// File: rtl/pf_quant_serializer.sv
module pf_quant_serializer
  import pfq_pkg::*;
#(
  parameter  int NBLK  = 40,
  parameter  int REG_W = 8,
  parameter  int COLW  = 7,
  localparam int NREG  = NBLK / REG_W,
  localparam int AW    = $clog2(NREG + 3),
  localparam int HW    = $clog2(NBLK * PFQ_BLK_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [HW-1:0]    hpos,
  output logic             pf_pix,
  output logic [COLW-1:0]  pix_col
);

  localparam int LINE_PIX = NBLK * PFQ_BLK_PIX;

  logic            rst_meta, rst_q;
  pfq_phase_t      phase;
  logic [NBLK-1:0] pf_bits;
  logic [COLW-1:0] fg_col, bg_col;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  pfq_hcount #(.LINE_PIX(LINE_PIX), .HW(HW)) u_hcount (
    .clk   (clk),
    .rst_n (rst_q),
    .hpos  (hpos),
    .phase (phase)
  );

  pfq_regs #(.NBLK(NBLK), .REG_W(REG_W), .COLW(COLW), .NREG(NREG), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pf_bits (pf_bits),
    .fg_col  (fg_col),
    .bg_col  (bg_col)
  );

  pfq_shifter #(.NBLK(NBLK), .HW(HW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_q),
    .pf_bits (pf_bits),
    .hpos    (hpos),
    .phase   (phase),
    .pix_bit (pf_pix)
  );

  // Colour path stays ungated: a register write shows on the next pixel.
  assign pix_col = pf_pix ? fg_col : bg_col;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
  import pfq_pkg::*;
#(
  parameter  int NBLK  = 40,
  parameter  int REG_W = 8,
  parameter  int COLW  = 7,
  localparam int NREG  = NBLK / REG_W,
  localparam int AW    = $clog2(NREG + 3),
  localparam int HW    = $clog2(NBLK * PFQ_BLK_PIX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic [HW-1:0]    hpos,
  input logic             pf_pix,
  input logic [COLW-1:0]  pix_col
);

  localparam int LINE_PIX = NBLK * PFQ_BLK_PIX;

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos == HW'(LINE_PIX - 1)) |=> (hpos == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != HW'(LINE_PIX - 1)) |=> (hpos == $past(hpos) + HW'(1)));

  a_r4_block_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_pix != $past(pf_pix)) |-> (hpos[1:0] == 2'd0));

  a_r6_fg_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(NREG)) |=>
      (!pf_pix || pix_col == $past(wr_data[COLW-1:0])));

  a_r6_bg_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(NREG + 1)) |=>
      (pf_pix || pix_col == $past(wr_data[COLW-1:0])));

  a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(NREG + 2) && hpos[1:0] != 2'd3) |=> $stable(pix_col));

endmodule

bind pf_quant_serializer pfq_checker #(.NBLK(NBLK), .REG_W(REG_W), .COLW(COLW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .hpos    (hpos),
  .pf_pix  (pf_pix),
  .pix_col (pix_col)
);

// File: tb/sim_pf_quant_serializer.sv
`timescale 1ns/1ps
module sim_pf_quant_serializer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] hpos;
  logic       pf_pix;
  logic [6:0] pix_col;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pf_quant_serializer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hpos(hpos), .pf_pix(pf_pix), .pix_col(pix_col)
  );

  // {pattern[39:0] (bit b = block b), foreground[6:0], background[6:0]}
  localparam logic [53:0] VEC [4] = '{
    {40'h00_0000_0000, 7'h11, 7'h22},
    {40'hFF_FFFF_FFFF, 7'h33, 7'h04},
    {40'hA5_0F_F0_3C_81, 7'h7F, 7'h00},
    {40'h80_0000_0001, 7'h40, 7'h01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (hpos != 8'(p)) @(negedge clk);
  endtask

  // Write issued in the cycle currently under way (its hpos is the write cycle).
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [39:0] pat, input logic [6:0] fg, input logic [6:0] bg);
    for (int r = 0; r < 5; r++) wr(3'(r), pat[r*8 +: 8]);
    wr(3'd5, {1'b0, fg});
    wr(3'd6, {1'b0, bg});
  endtask

  task automatic check_line(input logic [39:0] pat, input logic [6:0] fg,
                            input logic [6:0] bg, input string req);
    int bad = 0; int first = -1; int act = 0; int exp = 0;
    wait_pos(0);
    for (int p = 0; p < 160; p++) begin
      logic [6:0] e;
      e = pat[p/4] ? fg : bg;
      if (pf_pix !== pat[p/4] || pix_col !== e) begin
        if (first < 0) begin first = p; act = {pf_pix, pix_col}; exp = {pat[p/4], e}; end
        bad++;
      end
      if (p < 159) @(negedge clk);
    end
    chk(bad == 0, $sformatf("%s pixel %0d", req, first), act, exp);
  endtask

  task automatic finish_up;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(hpos == 8'd0, "R1 hpos", hpos, 0);
    chk(pf_pix == 1'b0, "R1 pf_pix", pf_pix, 0);
    chk(pix_col == 7'd0, "R1 pix_col", pix_col, 0);
    rst_n = 1'b1;

    // R2: wrap of the pixel counter
    wait_pos(159);
    @(negedge clk);
    chk(hpos == 8'd0, "R2 wrap", hpos, 0);
    @(negedge clk);
    chk(hpos == 8'd1, "R2 step", hpos, 1);

    // R3/R8: table of patterns, two lines each
    foreach (VEC[i]) begin
      logic [39:0] pat; logic [6:0] fg, bg;
      {pat, fg, bg} = VEC[i];
      wait_pos(0);
      load(pat, fg, bg);
      check_line(pat, fg, bg, "R3 line");
      check_line(pat, fg, bg, "R8 repeat");
    end

    // R5: block 10 fetched at pixel 37
    wait_pos(0);
    load(40'd0, 7'h55, 7'h0A);
    wait_pos(36);
    wr(3'd1, 8'h04);
    wait_pos(39);
    chk(pf_pix == 1'b0, "R4 before boundary", pf_pix, 0);
    @(negedge clk);
    chk(pf_pix == 1'b1, "R5 write at 36 seen at 40", pf_pix, 1);
    @(negedge clk);
    chk(pf_pix == 1'b1 && pix_col == 7'h55, "R4 whole block", {pf_pix, pix_col}, {1'b1, 7'h55});
    wait_pos(44);
    chk(pf_pix == 1'b0, "R3 block 11 clear", pf_pix, 0);

    wait_pos(0);
    wr(3'd1, 8'h00);
    wait_pos(37);
    wr(3'd1, 8'h04);
    wait_pos(40);
    chk(pf_pix == 1'b0, "R5 write at 37 missed this line", pf_pix, 0);
    wait_pos(40);
    chk(pf_pix == 1'b1, "R5 write at 37 seen next line", pf_pix, 1);

    // R5: block 0 fetched at pixel 157 of the previous line
    wait_pos(100);
    wr(3'd1, 8'h00);
    wait_pos(156);
    wr(3'd0, 8'h01);
    wait_pos(0);
    chk(pf_pix == 1'b1, "R5 block0 write at 156", pf_pix, 1);
    wait_pos(100);
    wr(3'd0, 8'h00);
    wait_pos(0);
    chk(pf_pix == 1'b0, "R5 block0 cleared", pf_pix, 0);
    wait_pos(157);
    wr(3'd0, 8'h01);
    wait_pos(0);
    chk(pf_pix == 1'b0, "R5 block0 write at 157 missed", pf_pix, 0);
    wait_pos(0);
    chk(pf_pix == 1'b1, "R5 block0 write at 157 next line", pf_pix, 1);

    // R6: colour writes show on the following pixel
    wait_pos(100);
    wr(3'd0, 8'h20);              // block 5 set, pixels 20..23
    wait_pos(21);
    chk(pix_col == 7'h55, "R6 fg old at write pixel", pix_col, 7'h55);
    wr(3'd5, 8'h3C);
    chk(pix_col == 7'h3C, "R6 fg new next pixel", pix_col, 7'h3C);
    wait_pos(29);
    chk(pix_col == 7'h0A, "R6 bg old at write pixel", pix_col, 7'h0A);
    wr(3'd6, 8'h66);
    chk(pix_col == 7'h66, "R6 bg new next pixel", pix_col, 7'h66);

    // R7: address 7 is ignored
    wait_pos(21);
    wr(3'd7, 8'hFF);
    chk(pix_col == 7'h3C, "R7 next pixel unchanged", pix_col, 7'h3C);
    check_line(40'h00_0000_0020, 7'h3C, 7'h66, "R7 line unchanged");

    finish_up();
  end

endmodule